// File: doc/BRIEF.md
# Bit-Level Pipelined 4x4 Unsigned Array Multiplier

This block multiplies two unsigned operands of `W` bits each (4 by default) and returns the full `2W`-bit product. Partial products are formed with two-input AND gates. They are added in shift-and-add order by full-adder cells that are arranged as an array. A register boundary follows every full-adder level, so the path between two registers is at most one full-adder cell deep. This suits a clock rate that no combinational or output-registered multiplier could reach.

The array has `2W-1` levels, which is seven for the default width. The first `W-1` levels each add one shifted partial-product row in carry-save form. The remaining `W` levels merge the upper half of the carry-save pair, one bit position per level, with the carry held in a register between levels. Operand bits and carry vectors that a later level needs are delayed alongside the data, so each level only ever combines bits that belong to the same operand pair.

A new operand pair may be presented on every clock edge. A valid flag travels through the same number of stages as the data. After reset the pipeline is empty.

Top module: `pipe_array_mul4`

## Requirements
- R1: `out_prod` equals the unsigned product `in_a * in_b` as a `2W`-bit value (8 bits for the default `W=4`), for every operand pair.
- R2: A pair sampled at a rising clock edge appears on `out_prod` exactly `2W-1` edges later (7 for `W=4`), and not one edge earlier.
- R3: `out_valid` reproduces `in_valid` delayed by the same `2W-1` edges. A low `in_valid` gives a low `out_valid` in that slot, even between valid pairs.
- R4: A new pair is accepted on every edge. Back-to-back pairs over all `2^(2W)` combinations each yield their own correct product.
- R5: While `rst_n` is low, `out_valid` and `out_prod` are 0, taking effect without waiting for a clock edge. After release, no stale valid result emerges.
- R6: All-ones operands give the largest product `(2^W-1)^2`, which is 225 for `W=4`. No valid product ever exceeds that value.
- R7: A zero operand gives a product of 0, even when it directly follows or precedes an all-ones pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every pipeline level updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears all stages |
| in_valid | input | 1 | Marks the operand pair on this edge as meaningful |
| in_a | input | W | Unsigned multiplicand |
| in_b | input | W | Unsigned multiplier |
| out_valid | output | 1 | High when `out_prod` holds a product of a valid pair |
| out_prod | output | 2W | Unsigned product |

## Verification
The bench streams every operand pair with no gaps. A design that lost alignment of a delayed operand bit or carry between levels would mix neighbouring pairs, and this shows up first around all-ones pairs that sit next to zeros. A single isolated pulse after idle cycles checks the latency edge by edge, so an extra or a missing register level shows as an early or a late valid. Holes in the valid pattern, and a reset asserted in the middle of a stream, expose a valid flag that is tied to the wrong stage or that leaks through reset. The top-bit merge at `2W-1` is driven to its limit by 15 x 15, where a dropped carry in the final ripple level would lose the most significant bit.

// File: rtl/pipe_array_mul4.sv
module pipe_array_mul4 #(
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [W-1:0]   in_a,
  input  logic [W-1:0]   in_b,
  output logic           out_valid,
  output logic [2*W-1:0] out_prod
);
  localparam int PW   = 2 * W;
  localparam int ROWS = W - 1;
  localparam int LAT  = 2 * W - 1;

  for (genvar lv = 1; lv <= LAT; lv++) begin : g_lv
    logic          v_i, v_q;
    logic [PW-1:0] s_i, s_n, s_q;

    if (lv == 1) begin : g_in
      assign v_i = in_valid;
      assign s_i = PW'(in_a & {W{in_b[0]}});
    end else begin : g_link
      assign v_i = g_lv[lv-1].v_q;
      assign s_i = g_lv[lv-1].s_q;
    end

    if (lv <= ROWS) begin : g_csa
      logic [W-1:0]    a_i;
      logic [W-lv-1:0] b_i;
      logic [PW-1:0]   c_i, pp, c_n, c_q;

      if (lv == 1) begin : g_first
        assign a_i = in_a;
        assign b_i = in_b[W-1:1];
        assign c_i = '0;
      end else begin : g_next
        assign a_i = g_lv[lv-1].g_csa.g_fwd.a_q;
        assign b_i = g_lv[lv-1].g_csa.g_fwd.b_q;
        assign c_i = g_lv[lv-1].g_csa.c_q;
      end

      assign pp  = PW'(a_i & {W{b_i[0]}}) << lv;
      assign s_n = s_i ^ c_i ^ pp;
      assign c_n = ((s_i & c_i) | (s_i & pp) | (c_i & pp)) << 1;

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) c_q <= '0;
        else        c_q <= c_n;

      if (lv < ROWS) begin : g_fwd
        logic [W-1:0]    a_q;
        logic [W-lv-2:0] b_q;
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
          end else begin
            a_q <= a_i;
            b_q <= b_i[W-lv-1:1];
          end
      end
    end else begin : g_rip
      logic [PW-lv-1:0] c_i;
      logic [W-1:0]     low;
      logic             cy_i, cy_n;

      if (lv == W) begin : g_first
        assign c_i  = g_lv[lv-1].g_csa.c_q[PW-1:W];
        assign low  = g_lv[lv-1].g_csa.c_q[W-1:0];
        assign cy_i = 1'b0;
      end else begin : g_next
        assign c_i  = g_lv[lv-1].g_rip.g_fwd.c_q;
        assign low  = '0;
        assign cy_i = g_lv[lv-1].g_rip.g_fwd.cy_q;
      end

      assign cy_n = (s_i[lv] & c_i[0]) | (s_i[lv] & cy_i) | (c_i[0] & cy_i);

      always_comb begin
        s_n          = s_i;
        s_n[W-1:0]   = s_i[W-1:0] ^ low;
        s_n[lv]      = s_i[lv] ^ c_i[0] ^ cy_i;
      end

      if (lv < LAT) begin : g_fwd
        logic [PW-lv-2:0] c_q;
        logic             cy_q;
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) begin
            c_q  <= '0;
            cy_q <= 1'b0;
          end else begin
            c_q  <= c_i[PW-lv-1:1];
            cy_q <= cy_n;
          end
      end
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        v_q <= 1'b0;
        s_q <= '0;
      end else begin
        v_q <= v_i;
        s_q <= s_n;
      end
  end

  assign out_valid = g_lv[LAT].v_q;
  assign out_prod  = g_lv[LAT].s_q;
endmodule

module pipe_array_mul4_chk #(
  parameter int W = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [W-1:0]   in_a,
  input logic [W-1:0]   in_b,
  input logic           out_valid,
  input logic [2*W-1:0] out_prod
);
  localparam int PW  = 2 * W;
  localparam int LAT = 2 * W - 1;
  localparam logic [PW-1:0] MAXP = PW'((2**W - 1) * (2**W - 1));

  logic [PW-1:0] ref_h [LAT];
  logic [LAT-1:0] vh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vh <= '0;
      for (int i = 0; i < LAT; i++) ref_h[i] <= '0;
    end else begin
      vh <= {vh[LAT-2:0], in_valid};
      ref_h[0] <= PW'(in_a) * PW'(in_b);
      for (int i = 1; i < LAT; i++) ref_h[i] <= ref_h[i-1];
    end

  always @(negedge clk)
    if (!rst_n) a_r5_reset_clear: assert (out_valid == 1'b0 && out_prod == '0);

  a_r3_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vh[LAT-1]);

  a_r1_product: assert property (@(posedge clk) disable iff (!rst_n)
    vh[LAT-1] |-> out_prod == ref_h[LAT-1]);

  a_r6_bound: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_prod <= MAXP);

  a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> vh[LAT-1]);
endmodule

bind pipe_array_mul4 pipe_array_mul4_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
  .out_valid(out_valid), .out_prod(out_prod)
);

// File: tb/pipe_array_mul4_tb.sv
`timescale 1ns/1ps
module pipe_array_mul4_tb;
  localparam int W   = 4;
  localparam int LAT = 2 * W - 1;
  localparam int NT  = 12;
  localparam int N   = NT + 256;

  // entry: {valid, a, b, expected product}
  localparam logic [16:0] TBL [NT] = '{
    {1'b1, 4'd15, 4'd15, 8'd225}, {1'b1, 4'd0,  4'd15, 8'd0},
    {1'b1, 4'd15, 4'd0,  8'd0},   {1'b1, 4'd1,  4'd1,  8'd1},
    {1'b0, 4'd9,  4'd7,  8'd63},  {1'b1, 4'd8,  4'd8,  8'd64},
    {1'b1, 4'd15, 4'd1,  8'd15},  {1'b1, 4'd1,  4'd15, 8'd15},
    {1'b1, 4'd10, 4'd5,  8'd50},  {1'b1, 4'd12, 4'd11, 8'd132},
    {1'b1, 4'd0,  4'd0,  8'd0},   {1'b1, 4'd14, 4'd13, 8'd182}
  };

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [W-1:0] in_a = '0, in_b = '0;
  logic out_valid;
  logic [2*W-1:0] out_prod;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [W-1:0]   sa [N];
  logic [W-1:0]   sb [N];
  logic           sv [N];
  logic [2*W-1:0] sp [N];

  always #2.5 clk = ~clk;

  pipe_array_mul4 #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_prod(out_prod)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < NT; i++) begin
      sv[i] = TBL[i][16];
      sa[i] = TBL[i][15:12];
      sb[i] = TBL[i][11:8];
      sp[i] = TBL[i][7:0];
    end
    for (int i = 0; i < 256; i++) begin
      sa[NT+i] = W'(i / 16);
      sb[NT+i] = W'(i % 16);
      sv[NT+i] = (i % 7) != 3;
      sp[NT+i] = 8'((i / 16) * (i % 16));
    end

    // R5: reset state
    repeat (3) @(negedge clk);
    chk("R5 valid in reset", int'(out_valid), 0);
    chk("R5 product in reset", int'(out_prod), 0);
    rst_n = 1'b1;

    // table then exhaustive back-to-back stream
    for (int t = 0; t < N + LAT; t++) begin
      @(negedge clk);
      if (t >= LAT) begin
        int k;
        string tg;
        k = t - LAT;
        if (sa[k] == 0 || sb[k] == 0)       tg = "R7";
        else if (sa[k] == 15 && sb[k] == 15) tg = "R6";
        else if (k >= NT)                   tg = "R4";
        else                                tg = "R1";
        chk("R3 valid slot", int'(out_valid), int'(sv[k]));
        if (sv[k]) chk(tg, int'(out_prod), int'(sp[k]));
      end
      if (t < N) begin
        in_valid = sv[t];
        in_a = sa[t];
        in_b = sb[t];
      end else begin
        in_valid = 1'b0;
      end
    end

    // R2: isolated pulse, exact latency
    repeat (LAT + 2) @(negedge clk);
    in_valid = 1'b1; in_a = 4'd9; in_b = 4'd13;
    @(negedge clk);
    in_valid = 1'b0; in_a = 4'd0; in_b = 4'd0;
    repeat (LAT - 2) @(negedge clk);
    chk("R2 not early", int'(out_valid), 0);
    @(negedge clk);
    chk("R2 valid on time", int'(out_valid), 1);
    chk("R2 product on time", int'(out_prod), 117);
    @(negedge clk);
    chk("R3 single pulse", int'(out_valid), 0);

    // R5: reset in the middle of a stream
    for (int i = 0; i < 4; i++) begin
      in_valid = 1'b1; in_a = 4'd15; in_b = 4'(i + 12);
      @(negedge clk);
    end
    #1 rst_n = 1'b0;
    #0.5;
    chk("R5 async valid", int'(out_valid), 0);
    chk("R5 async product", int'(out_prod), 0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < LAT + 1; i++) begin
      @(negedge clk);
      chk("R5 flushed", int'(out_valid), 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule